// File: doc/BRIEF.md
# Multi-port general-purpose-event merger

This block collects general-purpose-event (GPE) raise and release notifications from several downstream PCI Express ports and produces one upstream event stream. Each port delivers one-cycle pulses: one pulse on its raise input when a raise message arrives, and one pulse on its release input when a release message arrives. Per port, the block keeps a single bit that records an outstanding raise that has not yet been matched by a release.

The upstream side sees one merged level, which is the OR of all the per-port bits. A raise message goes upstream only when that level rises. A release message goes upstream only when every port has been serviced and the level falls. Messages are offered on a valid/ready handshake. A message that is still waiting when the level changes again is replaced by the newest level. If the level has returned to the value last accepted upstream, the waiting message is withdrawn.

A release on a port with no outstanding raise is ignored and reported on a one-cycle error flag. The current per-port bits are exposed as a status vector.

Top module: `gpe_merge`

## Requirements
- R1: After reset, every per-port bit is clear, `up_valid` is 0 and `proto_err` is 0.
- R2: A pulse on `raise_in[i]` alone sets `pend_vec[i]`, visible the cycle after the pulse is sampled.
- R3: A pulse on `release_in[i]` clears `pend_vec[i]` only, leaving the other ports' bits unchanged.
- R4: When the merged level rises from 0, `up_valid` goes to 1 with `up_kind` = 1 (1 = raise, 0 = release) in the cycle after the raise pulse is sampled.
- R5: A raise from another port while the merged level is already 1 creates no new upstream message.
- R6: A release message (`up_valid` = 1, `up_kind` = 0) is offered only once every bit of `pend_vec` is clear. While any bit remains set, no release is offered.
- R7: An offered message keeps `up_valid` and `up_kind` steady until `up_ready` is seen, and is retired on the accepting edge.
- R8: If the merged level returns to the value last accepted upstream before the waiting message is accepted, the message is withdrawn (`up_valid` falls) and nothing is sent.
- R9: A release on a port whose bit is already clear leaves `pend_vec` unchanged and raises `proto_err` for exactly one cycle, the cycle after the pulse.
- R10: If a port sees a raise and a release in the same cycle, the release is applied first: the bit reads 0 the next cycle, and the raise then takes effect one cycle later, setting the bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raise_in | input | NUM_PORTS | Per-port one-cycle raise message pulse |
| release_in | input | NUM_PORTS | Per-port one-cycle release message pulse |
| up_valid | output | 1 | Upstream message offered |
| up_kind | output | 1 | Upstream message type: 1 raise, 0 release |
| up_ready | input | 1 | Upstream accepts the offered message |
| pend_vec | output | NUM_PORTS | Per-port outstanding-raise bits |
| proto_err | output | 1 | One-cycle flag for a release with no outstanding raise |

## Verification
A wrong per-port bit appears on `pend_vec` one cycle after the pulse that caused it. It also spreads to the upstream side: a stuck bit keeps the merged level high, so the release message is never offered, and a lost bit causes an early release. Errors in the held message show up on the handshake itself. The bench checks for a message that changes while waiting, one that lingers after acceptance, and one that survives a return to the last sent level. Each of these is visible within one cycle of the edge that should have resolved it. The same-cycle raise and release case is timed cycle by cycle, so an ordering mistake shows as the wrong bit value in one of the two following cycles.

// File: rtl/gpe_merge_pkg.sv
package gpe_merge_pkg;

    // Per-port tracker state
    typedef struct packed {
        logic busy;   // outstanding raise
        logic defer;  // raise postponed by a same-cycle release
        logic err;    // release without outstanding raise
    } port_st_t;

    // Upstream message holder state
    typedef struct packed {
        logic level;  // merged level, registered
        logic sent;   // level last accepted upstream
    } up_st_t;

endpackage

// File: rtl/gpe_port_track.sv
module gpe_port_track
    import gpe_merge_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raise_p,
    input  logic release_p,
    output logic busy_d_o,
    output logic busy_o,
    output logic err_o
);

    port_st_t st_q, st_d;
    logic     eff_raise;

    always_comb begin
        st_d      = st_q;
        eff_raise = raise_p | st_q.defer;
        st_d.err  = release_p & ~st_q.busy;
        st_d.defer = eff_raise & release_p;
        if (release_p) begin
            st_d.busy = 1'b0;
        end else if (eff_raise) begin
            st_d.busy = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_d_o = st_d.busy;
    assign busy_o   = st_q.busy;
    assign err_o    = st_q.err;

    // R3: a release always leaves the bit clear afterwards
    a_r3_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
        release_p |=> !busy_o);

    // R2: a lone raise sets the bit
    a_r2_raise_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (raise_p && !release_p) |=> busy_o);

    // R9: unmatched release flags an error for one cycle
    a_r9_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (release_p && !busy_o) |=> err_o);

    // R10: same-cycle raise and release sets the bit one cycle later, absent a new release
    a_r10_defer_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (raise_p && release_p) |=> (!busy_o ##1 (busy_o || $past(release_p))));

endmodule

// File: rtl/gpe_up_msg.sv
module gpe_up_msg
    import gpe_merge_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level_d_i,
    input  logic ready_i,
    output logic valid_o,
    output logic kind_o
);

    up_st_t st_q, st_d;

    always_comb begin
        st_d       = st_q;
        st_d.level = level_d_i;
        if (valid_o && ready_i) begin
            st_d.sent = st_q.level;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.level ^ st_q.sent;
    assign kind_o  = st_q.level;

    // R7: a waiting message never changes its type
    a_r7_hold_kind: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> (!valid_o || $stable(kind_o)));

    // R7: an accepted message is not offered again
    a_r7_retire: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && ready_i) |=> !(valid_o && (kind_o == $past(kind_o))));

endmodule

// File: rtl/gpe_merge.sv
module gpe_merge
    import gpe_merge_pkg::*;
#(
    parameter int NUM_PORTS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] raise_in,
    input  logic [NUM_PORTS-1:0] release_in,
    output logic                 up_valid,
    output logic                 up_kind,
    input  logic                 up_ready,
    output logic [NUM_PORTS-1:0] pend_vec,
    output logic                 proto_err
);

    localparam int PW = NUM_PORTS;

    logic [PW-1:0] busy_d;
    logic [PW-1:0] busy_q;
    logic [PW-1:0] err_q;

    for (genvar i = 0; i < PW; i++) begin : g_port
        gpe_port_track u_trk (
            .clk       (clk),
            .rst_n     (rst_n),
            .raise_p   (raise_in[i]),
            .release_p (release_in[i]),
            .busy_d_o  (busy_d[i]),
            .busy_o    (busy_q[i]),
            .err_o     (err_q[i])
        );
    end

    gpe_up_msg u_up (
        .clk       (clk),
        .rst_n     (rst_n),
        .level_d_i (|busy_d),
        .ready_i   (up_ready),
        .valid_o   (up_valid),
        .kind_o    (up_kind)
    );

    assign pend_vec  = busy_q;
    assign proto_err = |err_q;

    // R4/R6: an offered message always matches the merged level of the port bits
    a_r6_kind_matches: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid |-> (up_kind == (|pend_vec)));

    // R5: a raise while already high creates no new offer
    a_r5_no_extra: assert property (@(posedge clk) disable iff (!rst_n)
        ((|pend_vec) && !up_valid && (release_in == '0)) |=> !up_valid);

    // R9: the error flag lasts one cycle unless retriggered
    a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (proto_err && (release_in == '0)) |=> !proto_err);

endmodule

// File: tb/gpe_merge_tb.sv
module gpe_merge_tb;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] raise_in = '0;
    logic [N-1:0] release_in = '0;
    logic         up_ready = 1'b0;
    logic         up_valid, up_kind, proto_err;
    logic [N-1:0] pend_vec;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    gpe_merge #(.NUM_PORTS(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .raise_in(raise_in), .release_in(release_in),
        .up_valid(up_valid), .up_kind(up_kind), .up_ready(up_ready),
        .pend_vec(pend_vec), .proto_err(proto_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive pulses for one cycle; return sampled just after the capturing edge
    task automatic pulse(input logic [N-1:0] r, input logic [N-1:0] d);
        @(negedge clk);
        raise_in = r; release_in = d;
        @(posedge clk); #1;
        raise_in = '0; release_in = '0;
    endtask

    task automatic idle();
        @(posedge clk); #1;
    endtask

    task automatic accept();
        @(negedge clk);
        up_ready = 1'b1;
        @(posedge clk); #1;
        up_ready = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 pend", pend_vec, 0);
        chk("R1 valid", up_valid, 0);
        chk("R1 err", proto_err, 0);
    endtask

    task automatic t_merge();
        pulse(4'b0001, 4'b0000);
        chk("R2 pend", pend_vec, 4'b0001);
        chk("R4 valid", up_valid, 1);
        chk("R4 kind", up_kind, 1);
        for (int k = 0; k < 3; k++) begin
            idle();
            chk("R7 hold valid", up_valid, 1);
            chk("R7 hold kind", up_kind, 1);
        end
        accept();
        chk("R7 retired", up_valid, 0);
        pulse(4'b0010, 4'b0000);
        chk("R5 pend", pend_vec, 4'b0011);
        chk("R5 no message", up_valid, 0);
        pulse(4'b0000, 4'b0001);
        chk("R3 pend", pend_vec, 4'b0010);
        chk("R6 no early release", up_valid, 0);
        pulse(4'b0000, 4'b0010);
        chk("R6 pend", pend_vec, 0);
        chk("R6 valid", up_valid, 1);
        chk("R6 kind", up_kind, 0);
        accept();
        chk("R7 retired release", up_valid, 0);
    endtask

    task automatic t_collapse();
        pulse(4'b0100, 4'b0000);
        chk("R8 offered", up_valid, 1);
        pulse(4'b0000, 4'b0100);
        chk("R8 withdrawn", up_valid, 0);
        idle();
        chk("R8 stays quiet", up_valid, 0);
    endtask

    task automatic t_err();
        pulse(4'b0000, 4'b1000);
        chk("R9 err", proto_err, 1);
        chk("R9 pend", pend_vec, 0);
        chk("R9 no message", up_valid, 0);
        idle();
        chk("R9 err one cycle", proto_err, 0);
    endtask

    task automatic t_same();
        pulse(4'b0001, 4'b0001);
        chk("R10 release first", pend_vec, 0);
        idle();
        chk("R10 raise later", pend_vec, 4'b0001);
        chk("R10 offer", up_valid, 1);
        accept();
        pulse(4'b0000, 4'b0001);
        chk("R10 cleanup", pend_vec, 0);
        accept();
        chk("R10 idle", up_valid, 0);
    endtask

    initial begin
        #(200000 * 20);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        idle();
        t_reset();
        t_merge();
        t_collapse();
        t_err();
        t_same();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule